// File: doc/BRIEF.md
# Bus Activity Reset Detector

This block sits on the cartridge side of a console bus. It tells whether the host is held in reset or is still powering up, and it does so without a reset pin. It watches two host signals: the CPU bus clock and address bit 0. Both are oversampled by a faster local clock. While the host runs, the bus clock toggles without pause and address bit 0 never holds one level for more than five CPU cycles. When the host is held in reset, both lines float, which is modelled here as a stuck level. A stuck bus clock, or an address bit that holds longer than its limit, therefore means reset.

Both inputs pass through a two-flop synchroniser. Each then feeds an activity timer that flags an edge and raises a stale flag after a set number of local ticks without an edge. A three-state machine combines the two timers. ST_HELD means the host is in reset with no confirmed activity. ST_CONFIRM means the host is in reset and bus clock edges are being counted. ST_RUN means the host is running.

The transitions are:
- HELD_TO_CONFIRM: a bus clock edge while address bit 0 is not stale.
- CONFIRM_TO_RUN: the counted edges reach the release count.
- CONFIRM_TO_HELD: either timer goes stale.
- RUN_TO_HELD: either timer goes stale.

The `in_reset` output is high in every state except ST_RUN. A one-cycle `reset_released` pulse marks the move into ST_RUN.

Top module: `bus_reset_detector`

## Requirements
- R1: After local reset, `in_reset` is 1 and `reset_released` is 0, and they stay so until activity is confirmed.
- R2: `in_reset` falls only after RELEASE_EDGES bus clock edges have been counted while both inputs are active. Fewer edges leave it at 1.
- R3: A bus clock stuck at 0 or at 1 for CLK_IDLE_TICKS local ticks drives `in_reset` to 1.
- R4: Address bit 0 holding one level for more than ADDR_IDLE_TICKS local ticks drives `in_reset` to 1. The default is 6 CPU cycles at CLK_RATIO ticks per cycle. A hold of 5 CPU cycles leaves `in_reset` at 0.
- R5: `reset_released` is high for exactly one local clock cycle, in the same cycle that `in_reset` first reads 0, once per release.
- R6: A burst of fewer than RELEASE_EDGES bus clock edges followed by silence produces no `reset_released` pulse, and `in_reset` stays 1 throughout.
- R7: After a return to reset from running, a fresh release again needs the full count of bus clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Local asynchronous reset, active low |
| bus_clk_raw | input | 1 | Host CPU bus clock, asynchronous to clk |
| addr0_raw | input | 1 | Host address bit 0, asynchronous to clk |
| in_reset | output | 1 | 1 while the host is judged to be in reset or power-up |
| reset_released | output | 1 | One-cycle pulse when in_reset falls |

## Verification
The hardest condition to reach is an address bit that holds for exactly the longest legal run while the bus clock keeps toggling. Only that hold tells the legal limit apart from a timeout set one cycle too short. The stimulus reaches it by stretching a single address interval to exactly five CPU cycles, and then, separately, to seven, counted from the toggle itself. A second hard case is a short burst of bus clock edges that stops before the release count. It checks that ST_CONFIRM falls back to ST_HELD without ever releasing.

// File: rtl/brd_pkg.sv
package brd_pkg;
    typedef enum logic [1:0] {
        ST_HELD    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_RUN     = 2'd2
    } det_state_t;
endpackage

// File: rtl/brd_sync2.sv
module brd_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            hold_q <= '0;
        end else begin
            meta_q <= d_async;
            hold_q <= meta_q;
        end
    end

    assign q_sync = hold_q;
endmodule

// File: rtl/brd_activity_timer.sv
module brd_activity_timer #(
    parameter int TIMEOUT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic edge_o,
    output logic stale_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic          prev_q;
    logic [CW-1:0] idle_q;

    assign edge_o  = (sig != prev_q);
    assign stale_o = (idle_q >= LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            idle_q <= LIMIT;
        end else begin
            prev_q <= sig;
            if (edge_o)
                idle_q <= '0;
            else if (idle_q < LIMIT)
                idle_q <= idle_q + 1'b1;
        end
    end

    // R3 / R4: the idle counter saturates at the limit
    a_r3_idle_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q <= LIMIT);

    // R4: an observed edge leaves the timer fresh on the next cycle
    a_r4_edge_clears_stale: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !stale_o);
endmodule

// File: rtl/brd_decide_fsm.sv
module brd_decide_fsm
    import brd_pkg::*;
#(
    parameter int RELEASE_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_edge,
    input  logic clk_stale,
    input  logic addr_stale,
    output logic in_reset,
    output logic released
);
    localparam int EW = $clog2(RELEASE_EDGES + 1);
    localparam logic [EW-1:0] LAST = EW'(RELEASE_EDGES - 1);

    det_state_t    state_q, state_n;
    logic [EW-1:0] cnt_q, cnt_n;
    logic          any_stale;

    assign any_stale = clk_stale | addr_stale;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_HELD: begin
                if (clk_edge && !addr_stale) begin
                    state_n = ST_CONFIRM;
                    cnt_n   = EW'(1);
                end
            end
            ST_CONFIRM: begin
                if (any_stale) begin
                    state_n = ST_HELD;
                    cnt_n   = '0;
                end else if (clk_edge) begin
                    if (cnt_q >= LAST) begin
                        state_n = ST_RUN;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (any_stale) begin
                    state_n = ST_HELD;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = ST_HELD;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HELD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_reset <= 1'b1;
            released <= 1'b0;
        end else begin
            in_reset <= (state_n != ST_RUN);
            released <= (state_q == ST_CONFIRM) && (state_n == ST_RUN);
        end
    end

    // R3: a silent bus clock puts the host back in reset
    a_r3_clk_stale_reset: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stale |=> in_reset);

    // R4: an over-long address hold puts the host back in reset
    a_r4_addr_stale_reset: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stale |=> in_reset);
endmodule

// File: rtl/bus_reset_detector.sv
module bus_reset_detector #(
    parameter int CLK_RATIO      = 4,
    parameter int ADDR_HOLD_CYC  = 6,
    parameter int CLK_IDLE_TICKS = 2 * CLK_RATIO,
    parameter int ADDR_IDLE_TICKS = ADDR_HOLD_CYC * CLK_RATIO,
    parameter int RELEASE_EDGES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk_raw,
    input  logic addr0_raw,
    output logic in_reset,
    output logic reset_released
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw_vec, sync_vec, edge_vec, stale_vec;

    assign raw_vec = {addr0_raw, bus_clk_raw};

    brd_sync2 #(.W(NSIG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_vec),
        .q_sync  (sync_vec)
    );

    for (genvar g = 0; g < NSIG; g++) begin : g_timer
        localparam int TMO = (g == 0) ? CLK_IDLE_TICKS : ADDR_IDLE_TICKS;
        brd_activity_timer #(.TIMEOUT(TMO)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .sig     (sync_vec[g]),
            .edge_o  (edge_vec[g]),
            .stale_o (stale_vec[g])
        );
    end

    brd_decide_fsm #(.RELEASE_EDGES(RELEASE_EDGES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_edge   (edge_vec[0]),
        .clk_stale  (stale_vec[0]),
        .addr_stale (stale_vec[1]),
        .in_reset   (in_reset),
        .released   (reset_released)
    );

    // R2: leaving reset always follows a counted bus clock edge
    a_r2_release_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_reset) |-> $past(edge_vec[0]));

    // R5: the release pulse coincides with the fall of in_reset
    a_r5_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        reset_released |-> (!in_reset && $past(in_reset)));

    // R5: the pulse lasts one cycle
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        reset_released |=> !reset_released);
endmodule

// File: tb/tb_bus_reset_detector.sv
module tb_bus_reset_detector;
    localparam int CLK_PERIOD = 10;
    localparam int RATIO      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_clk_raw = 1'b0;
    logic addr0_raw = 1'b0;
    logic in_reset, reset_released;

    int checks = 0;
    int failures = 0;

    bit bus_en = 0, addr_en = 0, bus_stop_level = 0;
    int bus_ph = 0, addr_ph = 0, addr_gap = RATIO;
    int rel_count = 0, hi_seen = 0, lo_seen = 0, pulse_bad = 0;

    bus_reset_detector #(.CLK_RATIO(RATIO)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_clk_raw    (bus_clk_raw),
        .addr0_raw      (addr0_raw),
        .in_reset       (in_reset),
        .reset_released (reset_released)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // stimulus drivers and monitors, all at the falling edge
    always @(negedge clk) begin
        if (bus_en) begin
            if (bus_ph >= RATIO - 1) begin bus_clk_raw = ~bus_clk_raw; bus_ph = 0; end
            else bus_ph = bus_ph + 1;
        end else begin
            bus_clk_raw = bus_stop_level;
            bus_ph = 0;
        end
        if (addr_en) begin
            if (addr_ph >= addr_gap - 1) begin addr0_raw = ~addr0_raw; addr_ph = 0; end
            else addr_ph = addr_ph + 1;
        end
        if (rst_n) begin
            if (reset_released) rel_count++;
            if (reset_released && in_reset) pulse_bad++;
            if (in_reset) hi_seen++; else lo_seen++;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state();
        ticks(3);
        rst_n = 1'b1;
        ticks(30);
        check("R1 in_reset after local reset", int'(in_reset), 1);
        check("R1 no release pulse", rel_count, 0);
    endtask

    task automatic t_short_burst();
        lo_seen = 0;
        addr_en = 1;
        bus_en = 1;
        ticks(2 * RATIO + 1);
        bus_stop_level = bus_clk_raw;
        bus_en = 0;
        ticks(40);
        check("R6 no release after short burst", rel_count, 0);
        check("R6 in_reset never fell", lo_seen, 0);
    endtask

    task automatic t_release();
        bus_en = 1;
        ticks(2 * RATIO + 2);
        check("R2 still in reset before edge count", int'(in_reset), 1);
        ticks(60);
        check("R2 released after enough edges", int'(in_reset), 0);
        check("R5 one pulse cycle", rel_count, 1);
        check("R5 pulse aligned with fall", pulse_bad, 0);
    endtask

    task automatic t_addr_hold(input int cpu_cycles, input int expect_hi);
        @(addr0_raw);
        addr_gap = cpu_cycles * RATIO;
        hi_seen = 0;
        @(addr0_raw);
        addr_gap = RATIO;
        ticks(6);
        check($sformatf("R4 hold of %0d cpu cycles", cpu_cycles),
              int'(hi_seen > 0), expect_hi);
    endtask

    task automatic t_bus_stuck(input bit level);
        bus_stop_level = level;
        bus_en = 0;
        ticks(25);
        check($sformatf("R3 bus clock stuck at %0d", level), int'(in_reset), 1);
        bus_en = 1;
        ticks(2 * RATIO + 2);
        check("R7 re-release needs full edge count", int'(in_reset), 1);
        ticks(60);
        check("R7 released again", int'(in_reset), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_short_burst();
        t_release();
        t_addr_hold(5, 0);
        check("R5 no extra pulse on legal hold", rel_count, 1);
        t_addr_hold(7, 1);
        ticks(60);
        check("R4 recovers after address resumes", int'(in_reset), 0);
        check("R5 second release pulse", rel_count, 2);
        t_bus_stuck(1'b0);
        t_bus_stuck(1'b1);
        check("R5 pulse count after stuck tests", rel_count, 4);
        check("R5 pulses never overlap in_reset", pulse_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule